// File: doc/BRIEF.md
# Operand Address Sequencer for an 8-bit Accumulator CPU

This unit sits between the instruction decoder and the execute stage of a small 8-bit accumulator processor. The decoder pulses `start` with an addressing-mode code, the current program counter, and the X, Y and accumulator values. The unit then walks through a short state machine. Each cycle it issues at most one byte read on a memory port whose data returns in the same cycle. It collects operand bytes and, where the mode needs them, pointer bytes. It returns a 16-bit effective address, the operand byte, the advanced program counter, and a flag that routes the result back into the accumulator.

The states are IDLE, OP0 (first operand byte at PC), OP1 (second operand byte), PTR0 (pointer low byte), PTR1 (pointer high byte), FETCH (operand at the effective address) and FIN (results valid, `done` high). The transitions are:

- IDLE→FIN on start in implied, accumulator or unused codes.
- IDLE→OP0 on start in any other mode.
- OP0→FIN for immediate and relative modes.
- OP0→FETCH for the zero-page modes.
- OP0→OP1 for the absolute modes and the indirect mode.
- OP0→PTR0 for the two zero-page-pointer modes.
- OP1→FETCH for the absolute modes.
- OP1→PTR0 for the indirect mode.
- PTR0→PTR1, PTR1→FETCH, FETCH→FIN and FIN→IDLE.

Results stay on the outputs until the next accepted start.

Top module: `ea_gen`

## Requirements
- R1: `start` is accepted only in IDLE and is ignored while a request is in flight. `done` is a single-cycle pulse that arrives N+1 clock edges after the accepting edge, where N is the number of memory reads the mode needs.
- R2: Codes 3 (zero page), 4 (zero page + X) and 5 (zero page + Y) form the address as {0x00, byte + index mod 256}, with the index taken as 0 for code 3. The operand is the byte read at that address (N=2).
- R3: Codes 7 (absolute), 8 (absolute + X) and 9 (absolute + Y) form a base address from two bytes: the low byte at PC and the high byte at PC+1. For codes 8 and 9 the index is added across all 16 bits, so a carry reaches the high byte. The operand is read at the result (N=3).
- R4: Code 10 (indirect) reads a pointer P from PC and PC+1. It then takes the low address byte at P and the high byte at {P[15:8], P[7:0]+1 mod 256}, so the high-byte fetch never crosses into the next page (N=5).
- R5: Code 11 (pre-indexed by X) selects the zero-page pointer Z = (byte + X) mod 256. It reads the address low byte at {0x00,Z} and the high byte at {0x00,(Z+1) mod 256}. The operand is read at that address (N=4).
- R6: Code 6 (relative) sign-extends the offset byte, so the upper byte is 0xFF when bit 7 is set and 0x00 otherwise. No operand read takes place, and the operand output carries the raw offset byte (N=1).
- R7: Code 12 (post-indexed by Y) reads a 16-bit pointer from zero page, with the low byte at {0x00,b} and the high byte at {0x00,(b+1) mod 256}. Y is then added to the full 16-bit pointer (N=4).
- R8: Code 1 (accumulator) makes no memory read. It raises `acc_wb` and returns the accumulator as the operand with address 0 (N=0). Every other code leaves `acc_wb` low.
- R9: Code 0 (implied) and the unused codes 13 to 15 make no read. They return address 0 and operand 0, and leave the PC unchanged (N=0).
- R10: `pc_out` equals the PC plus 2 for codes 7 to 10, the PC plus 1 for codes 2 to 6, 11 and 12, and the PC unchanged otherwise.
- R11: Code 2 (immediate) returns the PC as the address and the byte at the PC as the operand (N=1).
- R12: After reset the unit is idle with `done` and `mem_rd` low. It issues exactly N reads, one per cycle, and never reads in the cycle `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, sampled in IDLE |
| mode | input | 4 | Addressing-mode code (see requirements) |
| pc_in | input | 16 | PC pointing at the first operand byte |
| x_in | input | 8 | X index register |
| y_in | input | 8 | Y index register |
| a_in | input | 8 | Accumulator value |
| mem_addr | output | 16 | Read address |
| mem_rd | output | 1 | Read strobe, data returns in the same cycle |
| mem_rdata | input | 8 | Read data |
| done | output | 1 | Results valid, one-cycle pulse |
| ea | output | 16 | Effective address |
| operand | output | 8 | Operand byte |
| pc_out | output | 16 | Advanced PC |
| acc_wb | output | 1 | Write the result back to the accumulator |

## Verification
The hardest situations to reach are the wrap cases. One is a pointer whose low byte is 0xFF in indirect mode. Another is a zero-page pointer sitting at 0xFF in the two pointer modes, where the second fetch must wrap inside its page. Random PCs rarely produce these. The bench memory is therefore a closed-form byte function that is a bijection in the low address byte, and the bench searches it for the PC whose byte is 0xFF, or picks X so that byte + X lands on 0xFF. It pairs these cases with maximal X or Y so that the 16-bit index carry and the zero-page truncation are both exercised. A second start is also injected while an indirect request is mid-flight.

// File: rtl/eag_pkg.sv
package eag_pkg;

    typedef enum logic [3:0] {
        MD_NONE  = 4'd0,
        MD_ACCUM = 4'd1,
        MD_IMMED = 4'd2,
        MD_ZP    = 4'd3,
        MD_ZPX   = 4'd4,
        MD_ZPY   = 4'd5,
        MD_REL   = 4'd6,
        MD_ABS   = 4'd7,
        MD_ABSX  = 4'd8,
        MD_ABSY  = 4'd9,
        MD_PTR   = 4'd10,
        MD_PREX  = 4'd11,
        MD_POSTY = 4'd12
    } mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OP0,
        ST_OP1,
        ST_PTR0,
        ST_PTR1,
        ST_FETCH,
        ST_FIN
    } state_e;

endpackage

// File: rtl/eag_ctrl.sv
module eag_ctrl
    import eag_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [3:0]   mode_in,
    output state_e       state,
    output mode_e        mode_q
);

    state_e state_nx;
    mode_e  mode_cur;

    assign mode_cur = mode_e'(mode_in);

    // state register and latched mode
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            mode_q <= MD_NONE;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE && start) begin
                mode_q <= mode_cur;
            end
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    unique case (mode_cur)
                        MD_IMMED, MD_ZP, MD_ZPX, MD_ZPY, MD_REL,
                        MD_ABS, MD_ABSX, MD_ABSY, MD_PTR,
                        MD_PREX, MD_POSTY: state_nx = ST_OP0;
                        default:           state_nx = ST_FIN;
                    endcase
                end
            end
            ST_OP0: begin
                unique case (mode_q)
                    MD_ZP, MD_ZPX, MD_ZPY:      state_nx = ST_FETCH;
                    MD_ABS, MD_ABSX, MD_ABSY,
                    MD_PTR:                     state_nx = ST_OP1;
                    MD_PREX, MD_POSTY:          state_nx = ST_PTR0;
                    default:                    state_nx = ST_FIN;
                endcase
            end
            ST_OP1: begin
                if (mode_q == MD_PTR) state_nx = ST_PTR0;
                else                  state_nx = ST_FETCH;
            end
            ST_PTR0:  state_nx = ST_PTR1;
            ST_PTR1:  state_nx = ST_FETCH;
            ST_FETCH: state_nx = ST_FIN;
            ST_FIN:   state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/eag_path.sv
module eag_path
    import eag_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int ADDR_W = 2 * DATA_W
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [3:0]        mode_in,
    input  state_e            state,
    input  mode_e             mode_q,
    input  logic [ADDR_W-1:0] pc_in,
    input  logic [DATA_W-1:0] x_in,
    input  logic [DATA_W-1:0] y_in,
    input  logic [DATA_W-1:0] a_in,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              done,
    output logic [ADDR_W-1:0] ea,
    output logic [DATA_W-1:0] operand,
    output logic [ADDR_W-1:0] pc_out,
    output logic              acc_wb
);

    localparam logic [DATA_W-1:0] ZPAGE = '0;

    logic [ADDR_W-1:0] pc_q, ptr_q, ea_q;
    logic [DATA_W-1:0] x_q, y_q, lo_q, opnd_q;
    logic              acc_q;

    logic [DATA_W-1:0] zp_x, zp_y, ptr_lo_nx;
    logic [ADDR_W-1:0] word, word_x, word_y;

    assign zp_x      = mem_rdata + x_q;
    assign zp_y      = mem_rdata + y_q;
    assign ptr_lo_nx = ptr_q[DATA_W-1:0] + 1'b1;
    assign word      = {mem_rdata, lo_q};
    assign word_x    = word + {ZPAGE, x_q};
    assign word_y    = word + {ZPAGE, y_q};

    // read address per state; pointer high fetch stays in its page
    always_comb begin
        mem_rd   = 1'b1;
        mem_addr = '0;
        unique case (state)
            ST_OP0, ST_OP1: mem_addr = pc_q;
            ST_PTR0:        mem_addr = ptr_q;
            ST_PTR1:        mem_addr = {ptr_q[ADDR_W-1:DATA_W], ptr_lo_nx};
            ST_FETCH:       mem_addr = ea_q;
            default:        mem_rd   = 1'b0;
        endcase
    end

    // output and working registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q   <= '0;
            ptr_q  <= '0;
            ea_q   <= '0;
            x_q    <= '0;
            y_q    <= '0;
            lo_q   <= '0;
            opnd_q <= '0;
            acc_q  <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        pc_q  <= pc_in;
                        x_q   <= x_in;
                        y_q   <= y_in;
                        ea_q  <= '0;
                        ptr_q <= '0;
                        if (mode_e'(mode_in) == MD_ACCUM) begin
                            acc_q  <= 1'b1;
                            opnd_q <= a_in;
                        end else begin
                            acc_q  <= 1'b0;
                            opnd_q <= '0;
                        end
                    end
                end
                ST_OP0: begin
                    pc_q <= pc_q + 1'b1;
                    lo_q <= mem_rdata;
                    unique case (mode_q)
                        MD_IMMED: begin
                            ea_q   <= pc_q;
                            opnd_q <= mem_rdata;
                        end
                        MD_REL: begin
                            ea_q   <= {{DATA_W{mem_rdata[DATA_W-1]}}, mem_rdata};
                            opnd_q <= mem_rdata;
                        end
                        MD_ZP:    ea_q  <= {ZPAGE, mem_rdata};
                        MD_ZPX:   ea_q  <= {ZPAGE, zp_x};
                        MD_ZPY:   ea_q  <= {ZPAGE, zp_y};
                        MD_PREX:  ptr_q <= {ZPAGE, zp_x};
                        MD_POSTY: ptr_q <= {ZPAGE, mem_rdata};
                        default: ;
                    endcase
                end
                ST_OP1: begin
                    pc_q <= pc_q + 1'b1;
                    unique case (mode_q)
                        MD_ABSX: ea_q  <= word_x;
                        MD_ABSY: ea_q  <= word_y;
                        MD_PTR:  ptr_q <= word;
                        default: ea_q  <= word;
                    endcase
                end
                ST_PTR0: lo_q <= mem_rdata;
                ST_PTR1: begin
                    if (mode_q == MD_POSTY) ea_q <= word_y;
                    else                    ea_q <= word;
                end
                ST_FETCH: opnd_q <= mem_rdata;
                default: ;
            endcase
        end
    end

    assign done    = (state == ST_FIN);
    assign ea      = ea_q;
    assign operand = opnd_q;
    assign pc_out  = pc_q;
    assign acc_wb  = acc_q;

endmodule

// File: rtl/ea_gen.sv
module ea_gen
    import eag_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int ADDR_W = 2 * DATA_W
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [3:0]        mode,
    input  logic [ADDR_W-1:0] pc_in,
    input  logic [DATA_W-1:0] x_in,
    input  logic [DATA_W-1:0] y_in,
    input  logic [DATA_W-1:0] a_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              done,
    output logic [ADDR_W-1:0] ea,
    output logic [DATA_W-1:0] operand,
    output logic [ADDR_W-1:0] pc_out,
    output logic              acc_wb
);

    state_e state;
    mode_e  mode_q;

    eag_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .mode_in (mode),
        .state   (state),
        .mode_q  (mode_q)
    );

    eag_path #(.DATA_W(DATA_W)) u_path (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .mode_in   (mode),
        .state     (state),
        .mode_q    (mode_q),
        .pc_in     (pc_in),
        .x_in      (x_in),
        .y_in      (y_in),
        .a_in      (a_in),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_rd    (mem_rd),
        .done      (done),
        .ea        (ea),
        .operand   (operand),
        .pc_out    (pc_out),
        .acc_wb    (acc_wb)
    );

endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk
    import eag_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        done,
    input logic        mem_rd,
    input logic        acc_wb,
    input logic [15:0] ea,
    input mode_e       mode_q
);

    // R1: done lasts one cycle
    p_done_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R12: no read while results are presented
    p_no_read_at_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_rd);

    // R8: accumulator flag follows the accepted mode
    p_acc_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (acc_wb == (mode_q == MD_ACCUM)));

    // R8: accumulator mode reads nothing
    p_acc_noread_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && mode_q == MD_ACCUM) |-> !$past(mem_rd));

    // R2: zero-page modes stay on page zero
    p_zp_page_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (mode_q == MD_ZP || mode_q == MD_ZPX || mode_q == MD_ZPY))
        |-> (ea[15:8] == 8'h00));

    // R6: relative offset sign extension
    p_rel_sext_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && mode_q == MD_REL) |-> (ea[15:8] == {8{ea[7]}}));

endmodule

bind ea_gen ea_gen_chk u_chk (.*);

// File: tb/test_ea_gen.sv
`timescale 1ns/1ps
module test_ea_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  mode = '0;
    logic [15:0] pc_in = '0;
    logic [7:0]  x_in = '0, y_in = '0, a_in = '0;
    logic [15:0] mem_addr;
    logic        mem_rd;
    logic [7:0]  mem_rdata;
    logic        done;
    logic [15:0] ea;
    logic [7:0]  operand;
    logic [15:0] pc_out;
    logic        acc_wb;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    function automatic logic [7:0] mem_f(input logic [15:0] a);
        logic [7:0] lo, hi;
        lo = a[7:0] * 8'd37;
        hi = a[15:8] * 8'd11;
        return lo ^ hi ^ 8'h3C;
    endfunction

    assign mem_rdata = mem_f(mem_addr);

    ea_gen i_ea_gen (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .pc_in(pc_in), .x_in(x_in), .y_in(y_in), .a_in(a_in),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_rdata(mem_rdata),
        .done(done), .ea(ea), .operand(operand), .pc_out(pc_out),
        .acc_wb(acc_wb)
    );

    function automatic string tag_of(input logic [3:0] m);
        case (m)
            4'd1:             return "R8";
            4'd2:             return "R11";
            4'd3, 4'd4, 4'd5: return "R2";
            4'd6:             return "R6";
            4'd7, 4'd8, 4'd9: return "R3";
            4'd10:            return "R4";
            4'd11:            return "R5";
            4'd12:            return "R7";
            default:          return "R9";
        endcase
    endfunction

    // independent model of the requirements
    task automatic model(input logic [3:0] m, input logic [15:0] pc,
                         input logic [7:0] x, input logic [7:0] y, input logic [7:0] a,
                         output logic [15:0] e, output logic [7:0] op,
                         output logic [15:0] npc, output bit acc, output int nrd);
        logic [7:0]  b0, b1, z, z1, lo, hi;
        logic [15:0] p;
        b0 = mem_f(pc);
        b1 = mem_f(pc + 16'd1);
        acc = 0; e = '0; op = '0; npc = pc; nrd = 0;
        case (m)
            4'd1: begin acc = 1; op = a; end
            4'd2: begin e = pc; op = b0; npc = pc + 16'd1; nrd = 1; end
            4'd3, 4'd4, 4'd5: begin
                z = b0 + ((m == 4'd4) ? x : (m == 4'd5) ? y : 8'd0);
                e = {8'h00, z}; op = mem_f(e); npc = pc + 16'd1; nrd = 2;
            end
            4'd6: begin e = {{8{b0[7]}}, b0}; op = b0; npc = pc + 16'd1; nrd = 1; end
            4'd7, 4'd8, 4'd9: begin
                e = {b1, b0} + {8'h00, (m == 4'd8) ? x : (m == 4'd9) ? y : 8'd0};
                op = mem_f(e); npc = pc + 16'd2; nrd = 3;
            end
            4'd10: begin
                p = {b1, b0}; z1 = p[7:0] + 8'd1;
                lo = mem_f(p); hi = mem_f({p[15:8], z1});
                e = {hi, lo}; op = mem_f(e); npc = pc + 16'd2; nrd = 5;
            end
            4'd11, 4'd12: begin
                z = (m == 4'd11) ? b0 + x : b0; z1 = z + 8'd1;
                lo = mem_f({8'h00, z}); hi = mem_f({8'h00, z1});
                e = {hi, lo} + {8'h00, (m == 4'd12) ? y : 8'd0};
                op = mem_f(e); npc = pc + 16'd1; nrd = 4;
            end
            default: ;
        endcase
    endtask

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic run_op(input logic [3:0] m, input logic [15:0] pc,
                          input logic [7:0] x, input logic [7:0] y, input logic [7:0] a,
                          input bit poke);
        logic [15:0] e, npc;
        logic [7:0]  op;
        bit          acc;
        int          nrd, cycles, reads;
        model(m, pc, x, y, a, e, op, npc, acc, nrd);
        @(negedge clk);
        start = 1; mode = m; pc_in = pc; x_in = x; y_in = y; a_in = a;
        @(posedge clk);
        @(negedge clk);
        start = 0;
        cycles = 1; reads = 0;
        while (!done && cycles < 20) begin
            if (mem_rd) reads++;
            if (poke && cycles == 2) begin
                // R1: a second request while busy must be ignored
                start = 1; mode = 4'd0; pc_in = 16'h1111; x_in = 8'h55;
            end
            @(posedge clk);
            @(negedge clk);
            start = 0;
            cycles++;
        end
        chk("R1",  "latency",  cycles, nrd + 1);
        chk("R12", "reads",    reads,  nrd);
        chk("R12", "no read at done", int'(mem_rd), 0);
        chk(tag_of(m), "ea",      int'(ea),      int'(e));
        chk(tag_of(m), "operand", int'(operand), int'(op));
        chk("R10", "pc_out", int'(pc_out), int'(npc));
        chk("R8",  "acc_wb", int'(acc_wb), int'(acc));
        @(posedge clk);
        @(negedge clk);
        chk("R1", "done pulse", int'(done), 0);
    endtask

    function automatic logic [15:0] find_pc(input logic [7:0] hi, input logic [7:0] want);
        for (int i = 0; i < 256; i++) begin
            if (mem_f({hi, i[7:0]}) == want) return {hi, i[7:0]};
        end
        return {hi, 8'h00};
    endfunction

    function automatic logic [15:0] find_ptr_pc(input logic [7:0] hi);
        // PC whose first byte is 0xFF (pointer low byte at page end)
        return find_pc(hi, 8'hFF);
    endfunction

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000 && !finished) begin
                fails++;
                $display("FAIL watchdog expired");
                $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
                $finish;
            end
        end
    end

    initial begin : stim
        logic [15:0] p;
        int unused;
        unused = $urandom(32'h5EED);
        repeat (3) @(negedge clk);
        // R12: reset state
        chk("R12", "done at reset", int'(done), 0);
        chk("R12", "mem_rd at reset", int'(mem_rd), 0);
        rst_n = 1;
        @(negedge clk);
        chk("R12", "idle after reset", int'(mem_rd), 0);

        // directed corners
        run_op(4'd0,  16'h1234, 8'h01, 8'h02, 8'h03, 0);   // R9 implied
        run_op(4'd13, 16'h4321, 8'h01, 8'h02, 8'h03, 0);   // R9 unused code
        run_op(4'd15, 16'h0042, 8'h01, 8'h02, 8'h03, 0);   // R9 unused code
        run_op(4'd1,  16'h2000, 8'h10, 8'h20, 8'hA5, 0);   // R8 accumulator
        run_op(4'd2,  16'h30FF, 8'h00, 8'h00, 8'h00, 0);   // R11 immediate
        run_op(4'd4,  16'h0400, 8'hFF, 8'h00, 8'h00, 0);   // R2 zero-page wrap
        run_op(4'd5,  16'h0500, 8'h00, 8'hFF, 8'h00, 0);   // R2 zero-page wrap
        run_op(4'd8,  16'h0600, 8'hFF, 8'h00, 8'h00, 0);   // R3 carry into high byte
        run_op(4'd9,  16'h0700, 8'h00, 8'hFF, 8'h00, 0);   // R3 carry into high byte
        p = find_pc(8'h08, 8'h80);
        run_op(4'd6,  p, 8'h00, 8'h00, 8'h00, 0);          // R6 negative offset
        p = find_pc(8'h08, 8'h7F);
        run_op(4'd6,  p, 8'h00, 8'h00, 8'h00, 0);          // R6 positive offset
        p = find_ptr_pc(8'h09);
        run_op(4'd10, p, 8'h00, 8'h00, 8'h00, 0);          // R4 pointer at page end
        p = find_ptr_pc(8'h0A);
        run_op(4'd10, p, 8'h00, 8'h00, 8'h00, 1);          // R4 + R1 busy start
        p = 16'h0B10;
        run_op(4'd11, p, 8'hFF - mem_f(p), 8'h00, 8'h00, 0); // R5 pointer at 0xFF
        p = find_ptr_pc(8'h0C);
        run_op(4'd12, p, 8'h00, 8'hFF, 8'h00, 0);          // R7 pointer at 0xFF
        run_op(4'd3,  16'hFFFF, 8'h00, 8'h00, 8'h00, 0);   // R2 PC at top

        // constrained random
        for (int i = 0; i < 300; i++) begin
            run_op(4'($urandom_range(0, 15)), 16'($urandom), 8'($urandom),
                   8'($urandom), 8'($urandom), ($urandom_range(0, 9) == 0));
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule